// File: doc/BRIEF.md
# Flash Block Protection Manager

This block keeps the write-protection state of every erase block in a banked flash array. Software-facing command logic hands it lock, unlock and lock-down requests for a block index. The block applies each request against the level of the write-protect pin. Every block is in exactly one of three states: open (modifiable), locked, or frozen (locked down). A frozen block can be changed only while the write-protect pin is high.

When a program or erase operation starts, the block looks up the target block's state and samples the program-voltage permission once. It then answers with a one-cycle grant or deny pulse. After a grant, the operation stays running until the array controller ends it, whatever the program voltage does in the meantime. A separate status port returns the 2-bit state of any block one cycle after the request.

Top module: `blkprot_mgr`

## Requirements
- R1: One cycle after a synchronous reset is released, every block reads back as locked (01). `op_run`, `op_grant` and `op_deny` are all low.
- R2: A command changes only the block selected by `cmd_blk`; every other block keeps its state.
- R3: `cmd_code` 00 requests unlock (state becomes 00), 01 requests lock (state becomes 01), and 11 requests lock-down (state becomes 11, always, whatever the pin level). Code 10 is reserved and leaves the state unchanged.
- R4: While `wp_pin` is low, lock and unlock requests to a frozen (11) block leave it frozen.
- R5: While `wp_pin` is high, a lock request moves a frozen block to 01 and an unlock request moves it to 00.
- R6: An `op_start` accepted while no operation runs yields, on the next cycle, exactly one of two one-cycle pulses. It is `op_grant` when the target block is 00 and `vpp_ok` is high, and `op_deny` otherwise; the two are never high together.
- R7: `vpp_ok` is sampled only at the accepted start. A low level there denies even an open block. After a grant, `op_run` stays high until `op_end`, whatever `vpp_ok` does.
- R8: `op_start` while `op_run` is high is ignored: no grant or deny pulse, and `op_run` stays high.
- R9: With `rd_en` high, `rd_state` shows the state of block `rd_blk` after the next clock edge, and holds it while `rd_en` is low.
- R10: When a command and an `op_start` hit the same block in one cycle, the decision uses the state from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Protection command strobe |
| cmd_code | input | 2 | 00 unlock, 01 lock, 10 reserved, 11 lock-down |
| cmd_blk | input | BLK_W | Block index of the command |
| wp_pin | input | 1 | Write-protect pin level (low enforces lock-down) |
| rd_en | input | 1 | Status read request |
| rd_blk | input | BLK_W | Block index to read |
| rd_state | output | 2 | Registered state of the read block |
| vpp_ok | input | 1 | Program voltage above lockout threshold |
| op_start | input | 1 | Program or erase start |
| op_blk | input | BLK_W | Target block of the operation |
| op_end | input | 1 | Operation finished |
| op_grant | output | 1 | One-cycle grant pulse |
| op_deny | output | 1 | One-cycle deny pulse |
| op_run | output | 1 | Granted operation in progress |

## Verification
Several properties are checked on every cycle: the state after reset, mutual exclusion of grant and deny, grants only with a sampled voltage permission, the frozen state holding while the pin is low, and `op_run` persisting until `op_end`. Some behaviour shows only through the bench's scenarios. Examples are the full command-by-pin transition table, the isolation of one block from another, the status read latency, and the same-cycle ordering of a command against an operation start.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;
  typedef enum logic [1:0] {
    ST_OPEN   = 2'b00,
    ST_LOCK   = 2'b01,
    ST_FROZEN = 2'b11
  } prot_state_t;

  typedef enum logic [1:0] {
    CMD_UNLOCK = 2'b00,
    CMD_LOCK   = 2'b01,
    CMD_RSVD   = 2'b10,
    CMD_LOCKDN = 2'b11
  } prot_cmd_t;

  // Next state of one block for a command, given the pin level.
  function automatic logic [1:0] next_state(input logic [1:0] cur,
                                            input logic [1:0] cmd,
                                            input logic wp_high);
    logic [1:0] nxt;
    nxt = cur;
    case (cmd)
      CMD_LOCKDN: nxt = ST_FROZEN;
      CMD_LOCK:   if (cur != ST_FROZEN || wp_high) nxt = ST_LOCK;
      CMD_UNLOCK: if (cur != ST_FROZEN || wp_high) nxt = ST_OPEN;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/blkprot_cell.sv
module blkprot_cell
  import blkprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic [1:0] cmd,
  input  logic       wp_high,
  output logic [1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)      state <= ST_LOCK;
    else if (hit) state <= next_state(state, cmd, wp_high);
  end
endmodule

// File: rtl/blkprot_opgate.sv
module blkprot_opgate
  import blkprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       finish,
  input  logic [1:0] tgt_state,
  input  logic       vpp_ok,
  output logic       grant,
  output logic       deny,
  output logic       run
);
  logic accept, allow;
  assign accept = start && !run;
  assign allow  = (tgt_state == ST_OPEN) && vpp_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      deny  <= 1'b0;
      run   <= 1'b0;
    end else begin
      grant <= accept && allow;
      deny  <= accept && !allow;
      if (run && finish)          run <= 1'b0;
      else if (accept && allow)   run <= 1'b1;
    end
  end
endmodule

// File: rtl/blkprot_rdport.sv
module blkprot_rdport #(
  parameter int NB    = 128,
  parameter int BLK_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [BLK_W-1:0]     rd_blk,
  input  logic [NB-1:0][1:0]   states,
  output logic [1:0]           rd_state
);
  always_ff @(posedge clk) begin
    if (rst)        rd_state <= 2'b00;
    else if (rd_en) rd_state <= states[rd_blk];
  end
endmodule

// File: rtl/blkprot_mgr.sv
module blkprot_mgr #(
  parameter int NB    = 128,
  parameter int BLK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_code,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             wp_pin,
  input  logic             rd_en,
  input  logic [BLK_W-1:0] rd_blk,
  output logic [1:0]       rd_state,
  input  logic             vpp_ok,
  input  logic             op_start,
  input  logic [BLK_W-1:0] op_blk,
  input  logic             op_end,
  output logic             op_grant,
  output logic             op_deny,
  output logic             op_run
);
  logic [NB-1:0][1:0] state_vec;
  logic [1:0]         op_tgt;

  for (genvar i = 0; i < NB; i++) begin : g_cell
    logic hit;
    assign hit = cmd_valid && (cmd_blk == BLK_W'(i));
    blkprot_cell u_cell (
      .clk(clk), .rst(rst), .hit(hit), .cmd(cmd_code),
      .wp_high(wp_pin), .state(state_vec[i])
    );
  end

  assign op_tgt = state_vec[op_blk];

  blkprot_opgate u_gate (
    .clk(clk), .rst(rst), .start(op_start), .finish(op_end),
    .tgt_state(op_tgt), .vpp_ok(vpp_ok),
    .grant(op_grant), .deny(op_deny), .run(op_run)
  );

  blkprot_rdport #(.NB(NB), .BLK_W(BLK_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_blk(rd_blk),
    .states(state_vec), .rd_state(rd_state)
  );
endmodule

// File: rtl/blkprot_mgr_chk.sv
module blkprot_mgr_chk #(
  parameter int NB    = 128,
  parameter int BLK_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [1:0]         cmd_code,
  input logic [BLK_W-1:0]   cmd_blk,
  input logic               wp_pin,
  input logic               vpp_ok,
  input logic               op_end,
  input logic               op_grant,
  input logic               op_deny,
  input logic               op_run,
  input logic [NB-1:0][1:0] state_vec
);
  p_reset_locked_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_vec == {NB{2'b01}}) && !op_run && !op_grant && !op_deny);

  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(op_grant && op_deny));

  p_grant_vpp_r7: assert property (@(posedge clk) disable iff (rst)
    op_grant |-> $past(vpp_ok));

  p_grant_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    op_grant |=> !op_grant);

  p_run_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (op_run && !op_end) |=> op_run);

  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !wp_pin && cmd_code != 2'b11 && state_vec[cmd_blk] == 2'b11)
      |=> state_vec[$past(cmd_blk)] == 2'b11);
endmodule

bind blkprot_mgr blkprot_mgr_chk #(.NB(NB), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_blk(cmd_blk), .wp_pin(wp_pin), .vpp_ok(vpp_ok), .op_end(op_end),
  .op_grant(op_grant), .op_deny(op_deny), .op_run(op_run),
  .state_vec(state_vec)
);

// File: tb/tb_blkprot_mgr.sv
module tb_blkprot_mgr;
  localparam int NB = 128;
  localparam int BW = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, wp_pin = 0, rd_en = 0, vpp_ok = 0, op_start = 0, op_end = 0;
  logic [1:0] cmd_code = 0;
  logic [BW-1:0] cmd_blk = 0, rd_blk = 0, op_blk = 0;
  logic [1:0] rd_state;
  logic op_grant, op_deny, op_run;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  blkprot_mgr #(.NB(NB)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_blk(cmd_blk), .wp_pin(wp_pin), .rd_en(rd_en), .rd_blk(rd_blk),
    .rd_state(rd_state), .vpp_ok(vpp_ok), .op_start(op_start),
    .op_blk(op_blk), .op_end(op_end), .op_grant(op_grant),
    .op_deny(op_deny), .op_run(op_run)
  );

  // {code[11:10], blk[9:3], wp[2], expected state[1:0]}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {2'b00, 7'd5,   1'b1, 2'b00},  // R3 unlock
    {2'b01, 7'd5,   1'b1, 2'b01},  // R3 lock
    {2'b11, 7'd5,   1'b0, 2'b11},  // R3 lock-down with pin low
    {2'b00, 7'd5,   1'b0, 2'b11},  // R4 unlock refused
    {2'b01, 7'd5,   1'b0, 2'b11},  // R4 lock refused
    {2'b01, 7'd5,   1'b1, 2'b01},  // R5 lock from frozen
    {2'b11, 7'd5,   1'b1, 2'b11},  // R3 lock-down with pin high
    {2'b00, 7'd5,   1'b1, 2'b00},  // R5 unlock from frozen
    {2'b10, 7'd5,   1'b1, 2'b00},  // R3 reserved code ignored
    {2'b11, 7'd127, 1'b0, 2'b11},  // R3 top index
    {2'b00, 7'd0,   1'b0, 2'b00},  // R4 pin low, non-frozen unlocks
    {2'b11, 7'd0,   1'b1, 2'b11}   // R3 lock-down block 0
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] code, input logic [BW-1:0] b, input logic wp);
    @(negedge clk);
    cmd_valid = 1; cmd_code = code; cmd_blk = b; wp_pin = wp;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic rd(input logic [BW-1:0] b, output logic [1:0] s);
    rd_en = 1; rd_blk = b;
    @(negedge clk);
    rd_en = 0;
    s = rd_state;
  endtask

  // Start an operation; returns {grant,deny} seen one cycle later.
  task automatic op(input logic [BW-1:0] b, input logic v, output logic [1:0] gd);
    op_start = 1; op_blk = b; vpp_ok = v;
    @(negedge clk);
    op_start = 0;
    gd = {op_grant, op_deny};
  endtask

  initial begin
    logic [1:0] s, gd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 run/grant/deny", {op_run, op_grant | op_deny}, 2'b00);
    rd(7'd0, s);   check("R1 block0", s, 2'b01);
    rd(7'd64, s);  check("R1 block64", s, 2'b01);
    rd(7'd127, s); check("R1 block127", s, 2'b01);

    for (int i = 0; i < NV; i++) begin
      do_cmd(VEC[i][11:10], VEC[i][9:3], VEC[i][2]);
      rd(VEC[i][9:3], s);
      check($sformatf("R3/R4/R5 vector %0d", i), s, VEC[i][1:0]);
    end

    rd(7'd1, s);   check("R2 block1 untouched", s, 2'b01);
    rd(7'd6, s);   check("R2 block6 untouched", s, 2'b01);
    rd(7'd5, s);   check("R2 block5 kept", s, 2'b00);
    rd(7'd127, s); check("R2 block127 kept", s, 2'b11);
    check("R9 hold while rd_en low", rd_state, 2'b11);

    op(7'd1, 1'b1, gd);  check("R6 locked block denied", gd, 2'b01);
    @(negedge clk);      check("R6 deny one cycle", {op_grant, op_deny}, 2'b00);
    op(7'd127, 1'b1, gd); check("R6 frozen block denied", gd, 2'b01);
    @(negedge clk);
    op(7'd5, 1'b0, gd);  check("R7 low vpp denied", gd, 2'b01);
    @(negedge clk);
    op(7'd5, 1'b1, gd);  check("R6 open block granted", gd, 2'b10);
    check("R7 run set", {1'b0, op_run}, 2'b01);
    vpp_ok = 0;
    repeat (4) @(negedge clk);
    check("R7 run held after vpp drop", {op_grant, op_run}, 2'b01);
    vpp_ok = 1;
    op(7'd5, 1'b1, gd);  check("R8 start during run ignored", gd, 2'b00);
    check("R8 run still high", {1'b0, op_run}, 2'b01);
    op_end = 1; @(negedge clk); op_end = 0;
    check("R7 run cleared by end", {1'b0, op_run}, 2'b00);

    // R10: unlock and start on locked block 20 in the same cycle
    cmd_valid = 1; cmd_code = 2'b00; cmd_blk = 7'd20; wp_pin = 1;
    op_start = 1; op_blk = 7'd20; vpp_ok = 1;
    @(negedge clk);
    cmd_valid = 0; op_start = 0;
    check("R10 pre-command state used", {op_grant, op_deny}, 2'b01);
    @(negedge clk);
    op(7'd20, 1'b1, gd); check("R10 later start granted", gd, 2'b10);

    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    check("R1 reset clears run", {op_grant | op_deny, op_run}, 2'b00);
    rd(7'd20, s); check("R1 relock after reset", s, 2'b01);
    rd(7'd5, s);  check("R1 relock block5", s, 2'b01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule